// File: doc/BRIEF.md
# Sequential Binary to Decimal Converter

This block turns a 12-bit unsigned binary number into four decimal digits. It takes several clock cycles and handles one input bit per cycle. On each cycle every decimal digit is doubled, working upward from the least significant digit, and the carry from the digit below is added in. When a doubled value reaches ten or more, ten is taken off and a carry goes to the next digit. After that pass, the top bit of the input shift register is shifted out and added into the least significant digit.

After the conversion the block also reports the position of the first significant digit, so a display or print routine can skip leading zeros. At least one digit is always kept. An optional ASCII view gives each digit as its character code. A host pulses `start_i` with a value on `value_i` while the block is idle. It then waits for the one-cycle `done_o` pulse, and the results stay on the outputs until the next accepted start.

Top module: `bin2dec_seq`

## Requirements
- R1: A start accepted on a rising edge while idle raises `busy_o`, and `done_o` is first visible after the twelfth rising edge that follows the accepting edge, so there is exactly one iteration per input bit.
- R2: `done_o` is high for exactly one cycle; `busy_o` is low during that cycle and stays low until the next accepted start.
- R3: After done, `digits_o` holds the decimal value of the input. The thousands digit is at bits [15:12], hundreds at [11:8], tens at [7:4] and units at [3:0], and every digit lies in 0..9.
- R4: `first_idx_o` is 0, 1 or 2 for the first nonzero digit among thousands, hundreds and tens, in that scan order. It is 3 (the units digit) when all three are zero.
- R5: `ascii_o` is each digit plus 8'h30 in the same nibble order as `digits_o`: the thousands character is at [31:24] and the units character at [7:0].
- R6: A start pulse while `busy_o` is high is ignored. The running conversion finishes on time with its original result.
- R7: The digit, index and ASCII outputs keep their values from done until the next accepted start.
- R8: After reset, `busy_o` and `done_o` are low, all digits are zero, `first_idx_o` is 3 and `ascii_o` reads "0000".
- R9: An input of 4095 gives digits 4,0,9,5 with index 0. An input of 0 gives all zeros with index 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion (accepted only while idle) |
| value_i | input | 12 | Unsigned binary value, sampled with start |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when results are ready |
| digits_o | output | 16 | Four BCD digits, thousands at the top |
| first_idx_o | output | 2 | Position of first significant digit (0 = thousands) |
| ascii_o | output | 32 | Character codes of the four digits |

## Verification
A digit that fails to subtract ten, or a carry that goes astray, shows up at the ports as a digit above nine or a wrong decimal value. It appears no later than the done pulse of the same conversion, and the internal overflow check catches a carry out of the top digit on the iteration where it happens. An iteration counter that is off by one moves the done pulse away from its fixed 12-cycle position and corrupts the lowest digits. A wrong scan order in the index logic is exposed by values below 10, 100 and 1000. A start that slips through while busy changes the result of the conversion in flight.

// File: rtl/bin2dec_pkg.sv
package bin2dec_pkg;

  typedef logic [3:0] bcd_t;

  typedef struct packed {
    bcd_t digit;
    logic carry;
  } dbl_res_t;

  // Double a digit and add the carry from below, then subtract ten when possible.
  function automatic dbl_res_t dbl_sub10(input bcd_t d, input logic cin);
    logic [4:0] twice;
    dbl_res_t   r;
    twice = {d, cin};
    if (twice >= 5'd10) begin
      r.digit = bcd_t'(twice - 5'd10);
      r.carry = 1'b1;
    end else begin
      r.digit = twice[3:0];
      r.carry = 1'b0;
    end
    return r;
  endfunction

  // Inject the outgoing input bit into the least significant digit.
  function automatic bcd_t inject_bit(input bcd_t d, input logic b);
    return d + bcd_t'(b);
  endfunction

  function automatic logic [7:0] to_char(input bcd_t d);
    return 8'h30 + {4'h0, d};
  endfunction

endpackage

// File: rtl/bin2dec_digit_cell.sv
module bin2dec_digit_cell
  import bin2dec_pkg::*;
(
  input  bcd_t dig_i,
  input  logic cy_i,
  output bcd_t dig_o,
  output logic cy_o
);
  dbl_res_t res;
  assign res   = dbl_sub10(dig_i, cy_i);
  assign dig_o = res.digit;
  assign cy_o  = res.carry;
endmodule

// File: rtl/bin2dec_lead_scan.sv
module bin2dec_lead_scan #(
  parameter int NUM_DIG = 4,
  localparam int IDX_W  = (NUM_DIG > 1) ? $clog2(NUM_DIG) : 1
) (
  input  logic [4*NUM_DIG-1:0] digits_i,
  output logic [IDX_W-1:0]     idx_o
);
  // Scan from the most significant digit down; the units digit is the fallback.
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = IDX_W'(NUM_DIG - 1);
    for (int k = 0; k < NUM_DIG - 1; k++) begin
      if (!found && digits_i[4*(NUM_DIG-1-k) +: 4] != 4'd0) begin
        idx_o = IDX_W'(k);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bin2dec_seq.sv
module bin2dec_seq
  import bin2dec_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int NUM_DIG  = 4,
  parameter bit ASCII_EN = 1'b1,
  localparam int IDX_W   = (NUM_DIG > 1) ? $clog2(NUM_DIG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [IN_W-1:0]      value_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [4*NUM_DIG-1:0] digits_o,
  output logic [IDX_W-1:0]     first_idx_o,
  output logic [8*NUM_DIG-1:0] ascii_o
);
  localparam int CNT_W = $clog2(IN_W + 1);

  bcd_t [NUM_DIG-1:0] dig_q;
  bcd_t [NUM_DIG-1:0] dig_pass;
  logic [NUM_DIG:0]   carry;
  logic [IN_W-1:0]    sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic               done_q;

  // Named internal events for the checker.
  logic accept_w;
  logic step_w;
  logic last_w;
  logic msb_w;
  logic top_carry_w;

  assign accept_w    = start_i & ~busy_q;
  assign step_w      = busy_q;
  assign last_w      = busy_q && (cnt_q == CNT_W'(IN_W - 1));
  assign msb_w       = sh_q[IN_W-1];
  assign carry[0]    = 1'b0;
  assign top_carry_w = carry[NUM_DIG];

  for (genvar i = 0; i < NUM_DIG; i++) begin : g_cell
    bin2dec_digit_cell u_cell (
      .dig_i (dig_q[i]),
      .cy_i  (carry[i]),
      .dig_o (dig_pass[i]),
      .cy_o  (carry[i+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        dig_q  <= '0;
        sh_q   <= value_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (step_w) begin
        for (int j = 1; j < NUM_DIG; j++) dig_q[j] <= dig_pass[j];
        dig_q[0] <= inject_bit(dig_pass[0], msb_w);
        sh_q     <= sh_q << 1;
        cnt_q    <= cnt_q + CNT_W'(1);
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign digits_o = dig_q;

  bin2dec_lead_scan #(.NUM_DIG(NUM_DIG)) u_scan (
    .digits_i (digits_o),
    .idx_o    (first_idx_o)
  );

  if (ASCII_EN) begin : g_ascii
    for (genvar a = 0; a < NUM_DIG; a++) begin : g_chr
      assign ascii_o[8*a +: 8] = to_char(dig_q[a]);
    end
  end else begin : g_no_ascii
    assign ascii_o = '0;
  end

endmodule

// File: rtl/bin2dec_seq_chk.sv
module bin2dec_seq_chk #(
  parameter int IN_W    = 12,
  parameter int NUM_DIG = 4,
  parameter int IDX_W   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [4*NUM_DIG-1:0] digits_o,
  input logic [IDX_W-1:0]     first_idx_o,
  input logic                 step_w,
  input logic                 top_carry_w
);
  int unsigned busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cycles <= 0;
    else if (busy_o) busy_cycles <= busy_cycles + 1;
    else busy_cycles <= 0;
  end

  // R1
  iter_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_cycles == IN_W);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |-> !top_carry_w);

  for (genvar d = 0; d < NUM_DIG; d++) begin : g_rng
    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      digits_o[4*d +: 4] <= 4'd9);
  end

  // R4
  lead_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (digits_o[4*NUM_DIG-1 -: 4] != 4'd0) |-> first_idx_o == '0);

  // R4
  lead_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_idx_o == IDX_W'(NUM_DIG - 1)) |-> digits_o[4*NUM_DIG-1:4] == '0);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(digits_o));

endmodule

bind bin2dec_seq bin2dec_seq_chk #(
  .IN_W(IN_W), .NUM_DIG(NUM_DIG), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .digits_o    (digits_o),
  .first_idx_o (first_idx_o),
  .step_w      (step_w),
  .top_carry_w (top_carry_w)
);

// File: tb/bin2dec_seq_tb.sv
module bin2dec_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] value = '0;
  logic        busy, done;
  logic [15:0] digits;
  logic [1:0]  fidx;
  logic [31:0] ascii;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bin2dec_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .value_i(value),
    .busy_o(busy), .done_o(done), .digits_o(digits),
    .first_idx_o(fidx), .ascii_o(ascii)
  );

  function automatic logic [15:0] ref_digits(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [1:0] ref_idx(input int v);
    if (v >= 1000) return 2'd0;
    if (v >= 100)  return 2'd1;
    if (v >= 10)   return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [31:0] ref_ascii(input logic [15:0] d);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'd48 + 8'(d[4*k +: 4]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [11:0] v, input bit poke);
    int n;
    logic [15:0] ed;
    ed = ref_digits(int'(v));
    @(negedge clk); start = 1'b1; value = v;
    @(negedge clk); start = 1'b0; value = 12'($urandom); n = 1;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    while (!done && n < 40) begin
      if (poke && n == 4) begin start = 1'b1; value = ~v; end
      else start = 1'b0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    chk(n == 13, "R1 done latency", n, 13);
    chk(busy == 1'b0, "R2 busy low at done", busy, 0);
    chk(digits == ed, poke ? "R6 result unaffected" : "R3 digits", digits, ed);
    chk(fidx == ref_idx(int'(v)), "R4 first index", fidx, ref_idx(int'(v)));
    chk(ascii == ref_ascii(ed), "R5 ascii", ascii, ref_ascii(ed));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R2 single pulse", {busy, done}, 0);
    @(negedge clk);
    chk(digits == ed && fidx == ref_idx(int'(v)), "R7 held", digits, ed);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(busy == 0 && done == 0, "R8 control", {busy, done}, 0);
    chk(digits == 16'h0 && fidx == 2'd3, "R8 digits/index", {digits, fidx}, 3);
    chk(ascii == 32'h30303030, "R8 ascii", ascii, 32'h30303030);
    // R9 corners
    run(12'd4095, 1'b0);
    chk(digits == 16'h4095 && fidx == 2'd0, "R9 max value", {digits, fidx}, {16'h4095, 2'd0});
    run(12'd0, 1'b0);
    chk(digits == 16'h0000 && fidx == 2'd3, "R9 zero value", {digits, fidx}, 3);
    run(12'd9, 1'b0);
    run(12'd10, 1'b0);
    run(12'd99, 1'b0);
    run(12'd100, 1'b0);
    run(12'd999, 1'b0);
    run(12'd1000, 1'b0);
    run(12'd2048, 1'b0);
    // R6 start pulses while busy
    run(12'd1234, 1'b1);
    run(12'd7, 1'b1);
    for (int i = 0; i < 40; i++) run(12'($urandom), (i % 5) == 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule